// File: doc/BRIEF.md
# Interrupt Priority Gate and Vector Selector

This block sits at the front of a processor's exception path. An external encoder presents a 3-bit interrupt request level. Zero means that nothing is requested, and 1 to 7 are priorities with 7 the highest. The block passes the level through a two-flop synchronizer and treats a level as valid only once two consecutive synchronized samples agree. It then compares the valid level against the priority mask in the status register. Level 7 gets through whatever the mask holds, but it is taken only once each time the request enters level 7.

When a request is accepted, the block raises an acknowledge request and holds the accepted level until the bus side answers. The answer can be one of three things: no hardware acknowledge, which selects the spurious vector 24; an autovector, which selects vector 24 plus the level; or a vector number supplied by the device. On that answer the block does three things. It pulses a take-exception strobe together with the vector number and its byte address in the 256-entry, 4-byte vector table. It loads the mask with the accepted level. It forces supervisor mode, which also switches the stack pointer selection to the supervisor stack. The execution unit can write the mask and the supervisor bit directly.

Top module: `irq_gate`

## Requirements
- R1: During and after reset, `sr_mask_o` is 7, `sr_sup_o` and `sp_sel_o` are 1, and `iack_o` and `take_o` are 0.
- R2: A level is synchronized by two flops and counts only when two consecutive synchronized samples match. A level applied before clock edge 1 raises `iack_o` after edge 4 and not earlier. A level present for a single cycle is never accepted.
- R3: A valid level from 1 to 6 is accepted only when it is strictly greater than `sr_mask_o`. A level equal to or below the mask leaves `iack_o` at 0 and the status fields unchanged.
- R4: Level 7 is accepted for any mask value, including 7. It is accepted once for each entry into level 7, and a level held at 7 is not accepted again until a valid level other than 7 has been seen.
- R5: Level 0 is never accepted.
- R6: When the response arrives, `sr_mask_o` takes the accepted level, and `sr_sup_o` and `sp_sel_o` become 1. All three are visible in the same cycle as `take_o`.
- R7: The `resp_kind_i` encoding selects the vector. Code 0 means no acknowledge and selects vector 24. Code 1 means autovector and selects 24 plus the level, so levels 1 to 7 map to vectors 25 to 31. Code 2 passes `resp_vec_i` through. Code 3 is treated like code 0.
- R8: `vec_addr_o` equals 4 times `vec_num_o`, which places it in the range 0 to 1023.
- R9: A pulse on `sr_wr_i` loads `sr_mask_o` and `sr_sup_o` at the next edge. `sp_sel_o` is 1 in supervisor mode and 0 in user mode.
- R10: While `iack_o` is high, `iack_lvl_o` holds the accepted level and no new request is taken. A request that still qualifies is accepted on the first cycle after `take_o`.
- R11: `take_o` is a single-cycle pulse, asserted one edge after `resp_valid_i` is sampled high while `iack_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lvl_i | input | 3 | Encoded request level, asynchronous |
| sr_wr_i | input | 1 | Status field write strobe |
| sr_mask_i | input | 3 | Mask value to write |
| sr_sup_i | input | 1 | Supervisor bit to write |
| resp_valid_i | input | 1 | Acknowledge response present |
| resp_kind_i | input | 2 | 0 none, 1 autovector, 2 supplied vector, 3 none |
| resp_vec_i | input | 8 | Vector number supplied by the device |
| iack_o | output | 1 | Acknowledge request pending |
| iack_lvl_o | output | 3 | Level being acknowledged |
| take_o | output | 1 | Take-exception pulse |
| vec_num_o | output | 8 | Selected vector number |
| vec_addr_o | output | 10 | Byte address of the vector entry |
| sr_mask_o | output | 3 | Current priority mask |
| sr_sup_o | output | 1 | Supervisor mode bit |
| sp_sel_o | output | 1 | 1 selects the supervisor stack pointer |

## Verification
Two situations are the hardest to reach from the ports. The first is the level-7 re-arm: the mask alone never blocks level 7, so only the edge-tracking state decides whether it is taken. The bench first holds 7 past an acceptance with the mask lowered to 0. It then drops the level to 0 and raises it again to show the re-arm. The second is a request that arrives while an acknowledge is pending. The bench raises level 7 during the wait, confirms that the pending level does not move, and then expects the new request to fire on the cycle right after the take pulse. A sweep over every mask, level and response kind covers the compare and the vector selection.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int LW        = 3,
  parameter int VW        = 8,
  parameter int SPUR_VEC  = 24,
  parameter int AUTO_BASE = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] irq_lvl_i,
  input  logic          sr_wr_i,
  input  logic [LW-1:0] sr_mask_i,
  input  logic          sr_sup_i,
  input  logic          resp_valid_i,
  input  logic [1:0]    resp_kind_i,
  input  logic [VW-1:0] resp_vec_i,
  output logic          iack_o,
  output logic [LW-1:0] iack_lvl_o,
  output logic          take_o,
  output logic [VW-1:0] vec_num_o,
  output logic [VW+1:0] vec_addr_o,
  output logic [LW-1:0] sr_mask_o,
  output logic          sr_sup_o,
  output logic          sp_sel_o
);
  localparam logic [LW-1:0] TOP = {LW{1'b1}};

  logic [LW-1:0] s1, s2, s3;
  logic          armed;
  logic [VW-1:0] vsel;

  wire lvl_ok  = (s2 == s3);
  wire hit_top = (s2 == TOP);
  wire want    = !iack_o && lvl_ok && (s2 != '0) &&
                 (hit_top ? armed : (s2 > sr_mask_o));

  always_comb begin
    case (resp_kind_i)
      2'd1:    vsel = VW'(AUTO_BASE) + VW'(iack_lvl_o);
      2'd2:    vsel = resp_vec_i;
      default: vsel = VW'(SPUR_VEC);
    endcase
  end

  assign sp_sel_o = sr_sup_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1         <= '0;
      s2         <= '0;
      s3         <= '0;
      armed      <= 1'b1;
      iack_o     <= 1'b0;
      iack_lvl_o <= '0;
      take_o     <= 1'b0;
      vec_num_o  <= '0;
      vec_addr_o <= '0;
      sr_mask_o  <= TOP;
      sr_sup_o   <= 1'b1;
    end else begin
      s1     <= irq_lvl_i;
      s2     <= s1;
      s3     <= s2;
      take_o <= 1'b0;
      if (lvl_ok && !hit_top) armed <= 1'b1;
      if (want) begin
        iack_o     <= 1'b1;
        iack_lvl_o <= s2;
        if (hit_top) armed <= 1'b0;
      end
      if (iack_o && resp_valid_i) begin
        iack_o     <= 1'b0;
        take_o     <= 1'b1;
        vec_num_o  <= vsel;
        vec_addr_o <= {vsel, 2'b00};
        sr_mask_o  <= iack_lvl_o;
        sr_sup_o   <= 1'b1;
      end else if (sr_wr_i) begin
        sr_mask_o <= sr_mask_i;
        sr_sup_o  <= sr_sup_i;
      end
    end
  end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int LW        = 3,
  parameter int VW        = 8,
  parameter int SPUR_VEC  = 24,
  parameter int AUTO_BASE = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] irq_lvl_i,
  input logic          resp_valid_i,
  input logic [1:0]    resp_kind_i,
  input logic          iack_o,
  input logic [LW-1:0] iack_lvl_o,
  input logic          take_o,
  input logic [VW-1:0] vec_num_o,
  input logic [VW+1:0] vec_addr_o,
  input logic [LW-1:0] sr_mask_o,
  input logic          sr_sup_o
);
  localparam logic [LW-1:0] TOP = {LW{1'b1}};

  a_r2_stable_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack_o) |-> ($past(irq_lvl_i, 3) == iack_lvl_o) && ($past(irq_lvl_i, 4) == iack_lvl_o));

  a_r3_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack_o) |-> (iack_lvl_o > $past(sr_mask_o)) || (iack_lvl_o == TOP));

  a_r5_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |-> (iack_lvl_o != '0));

  a_r6_status_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (sr_mask_o == iack_lvl_o) && sr_sup_o);

  a_r7_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && ($past(resp_kind_i) == 2'd0) |-> (vec_num_o == VW'(SPUR_VEC)));

  a_r7_autovector: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && ($past(resp_kind_i) == 2'd1) |-> (vec_num_o == VW'(AUTO_BASE) + VW'(iack_lvl_o)));

  a_r8_addr: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vec_addr_o == {vec_num_o, 2'b00}));

  a_r10_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o && !resp_valid_i |=> iack_o && $stable(iack_lvl_o));

  a_r11_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
endmodule

bind irq_gate irq_gate_chk #(.LW(LW), .VW(VW), .SPUR_VEC(SPUR_VEC), .AUTO_BASE(AUTO_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq_lvl_i), .resp_valid_i(resp_valid_i),
  .resp_kind_i(resp_kind_i), .iack_o(iack_o), .iack_lvl_o(iack_lvl_o), .take_o(take_o),
  .vec_num_o(vec_num_o), .vec_addr_o(vec_addr_o), .sr_mask_o(sr_mask_o), .sr_sup_o(sr_sup_o)
);

// File: tb/irq_gate_tb.sv
module irq_gate_tb;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] irq_lvl = '0;
  logic       sr_wr = 1'b0;
  logic [2:0] sr_mask = '0;
  logic       sr_sup = 1'b0;
  logic       resp_valid = 1'b0;
  logic [1:0] resp_kind = '0;
  logic [7:0] resp_vec = '0;
  logic       iack, take, sup, sp_sel;
  logic [2:0] iack_lvl, mask;
  logic [7:0] vec;
  logic [9:0] addr;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  irq_gate u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq_lvl), .sr_wr_i(sr_wr), .sr_mask_i(sr_mask),
    .sr_sup_i(sr_sup), .resp_valid_i(resp_valid), .resp_kind_i(resp_kind), .resp_vec_i(resp_vec),
    .iack_o(iack), .iack_lvl_o(iack_lvl), .take_o(take), .vec_num_o(vec), .vec_addr_o(addr),
    .sr_mask_o(mask), .sr_sup_o(sup), .sp_sel_o(sp_sel)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sr_write(input logic [2:0] m, input logic s);
    sr_wr = 1'b1; sr_mask = m; sr_sup = s;
    step(1);
    sr_wr = 1'b0;
  endtask

  task automatic respond(input logic [1:0] k, input logic [7:0] v);
    resp_valid = 1'b1; resp_kind = k; resp_vec = v;
    step(1);
    resp_valid = 1'b0;
  endtask

  function automatic logic [7:0] exp_vec(input int k, input int l, input logic [7:0] v);
    if (k == 1) return 8'(24 + l);
    if (k == 2) return v;
    return 8'd24;
  endfunction

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 mask in reset", 32'(mask), 32'd7);
    chk("R1 sup in reset", 32'({sup, sp_sel}), 32'b11);
    rst_n = 1'b1;
    step(1);
    chk("R1 idle after reset", 32'({iack, take}), 32'd0);
    chk("R1 mask after reset", 32'(mask), 32'd7);

    // R9 status write and stack select
    sr_write(3'd2, 1'b0);
    chk("R9 mask write", 32'(mask), 32'd2);
    chk("R9 user stack", 32'({sup, sp_sel}), 32'b00);
    sr_write(3'd2, 1'b1);
    chk("R9 supervisor stack", 32'(sp_sel), 32'd1);

    // R2 single-cycle pulse ignored
    sr_write(3'd0, 1'b0);
    irq_lvl = 3'd5; step(1); irq_lvl = 3'd0;
    step(6);
    chk("R2 glitch ignored", 32'(iack), 32'd0);

    // R5 level zero held
    step(4);
    chk("R5 level zero", 32'(iack), 32'd0);

    // Sweep: R2 latency, R3/R4 compare, R6, R7, R8, R11
    for (int m = 0; m < 8; m++) begin
      for (int l = 1; l < 8; l++) begin
        for (int k = 0; k < 4; k++) begin
          logic acc;
          logic [7:0] v;
          acc = (l > m) || (l == 7);
          v = 8'(64 + 8*m + l);
          sr_write(3'(m), 1'b0);
          irq_lvl = 3'(l);
          step(3);
          chk("R2 not before edge 4", 32'(iack), 32'd0);
          step(1);
          chk(l == 7 ? "R4 top level accept" : "R3 mask compare", 32'(iack), 32'(acc));
          if (acc) begin
            chk("R10 pending level", 32'(iack_lvl), 32'(l));
            respond(2'(k), v);
            chk("R11 take pulse", 32'(take), 32'd1);
            chk("R7 vector", 32'(vec), 32'(exp_vec(k, l, v)));
            chk("R8 vector address", 32'(addr), 32'(exp_vec(k, l, v)) * 4);
            chk("R6 mask loaded", 32'(mask), 32'(l));
            chk("R6 supervisor forced", 32'({sup, sp_sel}), 32'b11);
            step(1);
            chk("R11 take ends", 32'(take), 32'd0);
          end else begin
            step(2);
            chk("R3 ignored no ack", 32'(iack), 32'd0);
            chk("R3 ignored status", 32'({mask, sup}), 32'({3'(m), 1'b0}));
          end
          irq_lvl = 3'd0;
          step(4);
        end
      end
    end

    // R4 held level 7 does not retrigger; re-entry does
    sr_write(3'd0, 1'b0);
    irq_lvl = 3'd7;
    step(4);
    chk("R4 first entry", 32'(iack), 32'd1);
    respond(2'd1, 8'd0);
    chk("R4 autovector 31", 32'(vec), 32'd31);
    sr_write(3'd0, 1'b0);
    step(8);
    chk("R4 held no retrigger", 32'(iack), 32'd0);
    irq_lvl = 3'd0;
    step(4);
    irq_lvl = 3'd7;
    step(4);
    chk("R4 re-entry accepted", 32'(iack), 32'd1);
    respond(2'd0, 8'd0);
    chk("R7 spurious", 32'(vec), 32'd24);
    irq_lvl = 3'd0;
    step(4);

    // R10 pending request blocks new one, fires after take
    sr_write(3'd1, 1'b0);
    irq_lvl = 3'd5;
    step(4);
    chk("R10 accept level 5", 32'(iack_lvl), 32'd5);
    irq_lvl = 3'd7;
    step(6);
    chk("R10 still pending", 32'(iack), 32'd1);
    chk("R10 level held", 32'(iack_lvl), 32'd5);
    respond(2'd1, 8'd0);
    chk("R10 take vector", 32'(vec), 32'd29);
    chk("R10 no ack in take cycle", 32'(iack), 32'd0);
    step(1);
    chk("R10 queued accept", 32'({iack, iack_lvl}), 32'({1'b1, 3'd7}));
    respond(2'd2, 8'd255);
    chk("R8 top address", 32'(addr), 32'd1020);
    irq_lvl = 3'd0;
    step(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule